// File: doc/BRIEF.md
# Pointer-Addressed Serial Register Bank

This block holds the registers of a byte-oriented serial slave, together with the pointer that selects which register the next byte reaches. A bus front end, outside this block, turns line activity into byte events: a start marker, a received byte, a request for a byte to transmit, and a stop marker. The block takes the first received byte of a transaction as an address byte. It decides whether to acknowledge that byte, and bit 0 of the byte sets the direction. In a write transaction the next byte loads the control byte, which holds the pointer and the auto-increment flags, and every later byte is stored in the register the pointer names. In a read transaction each request returns the pointed register.

After each access the pointer moves according to the auto-increment flags. It can stay fixed, step through the whole map, or wrap inside the brightness band, inside the group band, or inside both bands together. The slave always answers its fixed own address. It also answers three alias addresses and one broadcast address, which are stored in registers, but only while the matching enable bits are set in the primary configuration register.

The register map with the default parameters:

- 00h: primary configuration. Bits 7:5 are the auto-increment view, bit 4 is sleep, bits 3, 2 and 1 enable aliases 1, 2 and 3, and bit 0 enables broadcast.
- 01h: secondary configuration.
- 02h–09h: eight brightness levels.
- 0Ah: group level.
- 0Bh: group rate.
- 0Ch–0Dh: output select.
- 0Eh–10h: alias addresses 1 to 3.
- 11h: broadcast address.

Pointer values 12h–1Fh are undefined.

Top module: `serial_regbank`

## Requirements
- R1: After synchronous reset, register 00h reads 11h (auto-increment view 000, sleep 1, broadcast enable 1, alias enables 0). Register 01h reads 05h, the alias registers read E2h, E4h and E8h, the broadcast register reads E0h, and all other registers read 00h. The control byte resets to 00h, so the pointer is 00h with auto-increment off.
- R2: The first byte after a start is the address byte. Bits 7:1 are compared with the own address, and bit 0 set to 1 selects read while 0 selects write. For every byte received, ack_valid pulses one cycle later and ack carries the decision.
- R3: An address byte also matches alias 1, 2 or 3 when bit 3, 2 or 1 of register 00h is set and bits 7:1 of that alias register are equal to its bits 7:1. It matches broadcast when bit 0 is set and the same comparison holds against the broadcast register. With reset values, E2h is not acknowledged and E0h is.
- R4: In a matched write, the first data byte is acknowledged and loads the control byte: bits 4:0 form the pointer and bits 7:5 the auto-increment flags. Each later byte is acknowledged and stored at the pointer.
- R5: With flag bit 7 equal to 0 the pointer does not move, so repeated bytes reach the same register.
- R6: With flags 100 the pointer steps by one after each access and goes from 11h to 00h. Stepping from 1Fh also gives 00h.
- R7: Flags 101 wrap from 09h to 02h, flags 110 wrap from 0Bh to 0Ah, and flags 111 wrap from 0Bh to 02h. At any other pointer value these modes step by one.
- R8: In a matched read, each rd_req returns the pointed register on rd_data with rd_valid one cycle later, and the pointer then moves by the same rules as a write.
- R9: A write at pointer 12h–1Fh is acknowledged and changes no register. A read there returns 00h.
- R10: Bits 7:5 of register 00h always read as the current auto-increment flags. Writes to those bits have no effect.
- R11: Bytes that follow an unmatched address byte, and bytes received after a stop and before the next start, are not acknowledged. They change neither the control byte nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | One-cycle marker of a (repeated) start |
| bus_stop | input | 1 | One-cycle marker of a stop |
| rx_valid | input | 1 | A received byte is on rx_byte |
| rx_byte | input | 8 | Received byte (address or data) |
| rd_req | input | 1 | Request for the next byte to transmit |
| ack_valid | output | 1 | Acknowledge decision valid, one cycle after rx_valid |
| ack | output | 1 | 1 = byte acknowledged |
| rd_valid | output | 1 | rd_data valid, one cycle after an accepted rd_req |
| rd_data | output | 8 | Byte returned to the master |

## Verification
The bench builds the block with the default brightness count of eight and an own address of 15h. With these values the map has 18 registers, and the 5-bit pointer leaves the span 12h–1Fh undefined. That makes two cases reachable: a step from 1Fh back to 00h, and reads and writes at undefined pointers. With eight brightness levels, the 101 wrap takes nine accesses to show and the 111 wrap crosses the band boundary at 09h/0Ah. The bench also changes the enable and broadcast registers during the run, to show that address matching follows the live register contents.

// File: rtl/srf_pkg.sv
package srf_pkg;

    // The control byte splits as 3 flag bits over a 5-bit pointer.
    localparam int PTR_W = 5;
    localparam int AI_W  = 3;

    typedef struct packed {
        logic [AI_W-1:0]  ai;
        logic [PTR_W-1:0] ptr;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CTRL,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } bus_state_e;

    // Lower two flag bits choose the wrap band when bit 2 is set.
    typedef enum logic [1:0] {
        WRAP_ALL  = 2'b00,
        WRAP_BRT  = 2'b01,
        WRAP_GRP  = 2'b10,
        WRAP_BOTH = 2'b11
    } wrap_e;

    function automatic logic [PTR_W-1:0] step_ptr(
        input logic [PTR_W-1:0] cur,
        input logic [AI_W-1:0]  ai,
        input logic [PTR_W-1:0] last,
        input logic [PTR_W-1:0] brt_lo,
        input logic [PTR_W-1:0] brt_hi,
        input logic [PTR_W-1:0] grp_lo,
        input logic [PTR_W-1:0] grp_hi
    );
        logic [PTR_W-1:0] inc;
        inc = cur + PTR_W'(1);
        if (!ai[2]) return cur;
        case (wrap_e'(ai[1:0]))
            WRAP_ALL:  return (cur == last)   ? '0     : inc;
            WRAP_BRT:  return (cur == brt_hi) ? brt_lo : inc;
            WRAP_GRP:  return (cur == grp_hi) ? grp_lo : inc;
            default:   return (cur == grp_hi) ? brt_lo : inc;
        endcase
    endfunction

endpackage

// File: rtl/srf_addr_match.sv
module srf_addr_match #(
    parameter logic [6:0] OWN_ADDR = 7'h15,
    parameter int         N_ALIAS  = 3
) (
    input  logic [6:0]             addr7,
    input  logic [N_ALIAS-1:0]     alias_en,   // bit N_ALIAS-1 pairs with alias 0
    input  logic [N_ALIAS-1:0][6:0] alias_key,
    input  logic                   bcast_en,
    input  logic [6:0]             bcast_key,
    output logic                   hit
);
    logic [N_ALIAS-1:0] alias_hit;

    for (genvar k = 0; k < N_ALIAS; k++) begin : g_alias
        assign alias_hit[k] = alias_en[N_ALIAS-1-k] && (addr7 == alias_key[k]);
    end

    assign hit = (addr7 == OWN_ADDR) || (bcast_en && (addr7 == bcast_key)) || (|alias_hit);

endmodule

// File: rtl/srf_ptr_unit.sv
module srf_ptr_unit
    import srf_pkg::*;
#(
    parameter int LAST   = 17,
    parameter int BRT_LO = 2,
    parameter int BRT_HI = 9,
    parameter int GRP_LO = 10,
    parameter int GRP_HI = 11
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  ctrl_t load_val,
    input  logic  adv,
    output ctrl_t ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (load) begin
            ctrl_q <= load_val;
        end else if (adv) begin
            ctrl_q.ptr <= step_ptr(ctrl_q.ptr, ctrl_q.ai, PTR_W'(LAST), PTR_W'(BRT_LO),
                                   PTR_W'(BRT_HI), PTR_W'(GRP_LO), PTR_W'(GRP_HI));
        end
    end

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && !ctrl_q.ai[2]) |=> (ctrl_q.ptr == $past(ctrl_q.ptr)));

    // R6
    full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && ctrl_q.ai == 3'b100 && ctrl_q.ptr == PTR_W'(LAST)) |=> (ctrl_q.ptr == '0));

    // R7
    brt_band_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && ctrl_q.ai == 3'b101 && ctrl_q.ptr >= PTR_W'(BRT_LO) && ctrl_q.ptr <= PTR_W'(BRT_HI))
        |=> (ctrl_q.ptr >= PTR_W'(BRT_LO) && ctrl_q.ptr <= PTR_W'(BRT_HI)));

    // R7
    both_band_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && ctrl_q.ai == 3'b111 && ctrl_q.ptr == PTR_W'(GRP_HI)) |=> (ctrl_q.ptr == PTR_W'(BRT_LO)));

endmodule

// File: rtl/srf_reg_bank.sv
module srf_reg_bank
    import srf_pkg::*;
#(
    parameter int NUM_REGS = 18,
    parameter int CFG_A    = 0,
    parameter int CFG_B    = 1,
    parameter int ALIAS_LO = 14,
    parameter int N_ALIAS  = 3,
    parameter int BCAST    = 17
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [PTR_W-1:0]        wr_idx,
    input  logic [7:0]              wr_data,
    input  logic                    rd_en,
    input  logic [PTR_W-1:0]        rd_idx,
    input  logic [AI_W-1:0]         ai_view,
    output logic [7:0]              rd_data,
    output logic [N_ALIAS-1:0]      alias_en,
    output logic [N_ALIAS-1:0][6:0] alias_key,
    output logic                    bcast_en,
    output logic [6:0]              bcast_key
);
    logic [7:0] regs [NUM_REGS];

    function automatic logic [7:0] reset_val(input int idx);
        if (idx == CFG_A)                          return 8'h11;
        if (idx == CFG_B)                          return 8'h05;
        if (idx >= ALIAS_LO && idx < ALIAS_LO + N_ALIAS)
            return 8'hE0 | (8'h02 << (idx - ALIAS_LO));
        if (idx == BCAST)                          return 8'hE0;
        return 8'h00;
    endfunction

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= reset_val(i);
            end else if (wr_en && wr_idx == PTR_W'(i)) begin
                if (i == CFG_A) regs[i] <= {3'b000, wr_data[4:0]};
                else            regs[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (int'(rd_idx) >= NUM_REGS)      rd_data <= 8'h00;
            else if (rd_idx == PTR_W'(CFG_A))  rd_data <= {ai_view, regs[CFG_A][4:0]};
            else                               rd_data <= regs[rd_idx];
        end else begin
            rd_data <= '0;
        end
    end

    assign alias_en  = regs[CFG_A][N_ALIAS:1];
    assign bcast_en  = regs[CFG_A][0];
    assign bcast_key = regs[BCAST][7:1];
    for (genvar k = 0; k < N_ALIAS; k++) begin : g_key
        assign alias_key[k] = regs[ALIAS_LO+k][7:1];
    end

    // R9
    undef_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(rd_idx) >= NUM_REGS) |=> (rd_data == 8'h00));

    // R10
    ai_view_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_idx == PTR_W'(CFG_A)) |=> (rd_data[7:5] == $past(ai_view)));

endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
    import srf_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR  = 7'h15,
    parameter int         BRT_COUNT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rd_req,
    output logic       ack_valid,
    output logic       ack,
    output logic       rd_valid,
    output logic [7:0] rd_data
);
    // Map layout derived from the brightness count; must stay within 32 entries.
    localparam int CFG_A     = 0;
    localparam int CFG_B     = 1;
    localparam int BRT_LO    = 2;
    localparam int BRT_HI    = BRT_LO + BRT_COUNT - 1;
    localparam int GRP_LO    = BRT_HI + 1;
    localparam int GRP_HI    = GRP_LO + 1;
    localparam int OSEL_CNT  = (BRT_COUNT + 3) / 4;
    localparam int ALIAS_LO  = GRP_HI + 1 + OSEL_CNT;
    localparam int N_ALIAS   = 3;
    localparam int BCAST     = ALIAS_LO + N_ALIAS;
    localparam int NUM_REGS  = BCAST + 1;

    bus_state_e state;
    ctrl_t      ctrl_q;
    logic       hit;
    logic       quiet;
    logic       ctrl_load, wr_en, rd_en;

    logic [N_ALIAS-1:0]      alias_en;
    logic [N_ALIAS-1:0][6:0] alias_key;
    logic                    bcast_en;
    logic [6:0]              bcast_key;

    assign quiet     = !bus_start && !bus_stop;
    assign ctrl_load = rx_valid && quiet && (state == ST_CTRL);
    assign wr_en     = rx_valid && quiet && (state == ST_WDATA);
    assign rd_en     = rd_req && (state == ST_RDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            rd_valid  <= 1'b0;
        end else begin
            ack_valid <= rx_valid;
            ack       <= 1'b0;
            rd_valid  <= rd_en;
            if (bus_stop) begin
                state <= ST_IDLE;
            end else if (bus_start) begin
                state <= ST_ADDR;
            end else if (rx_valid) begin
                case (state)
                    ST_ADDR: begin
                        ack   <= hit;
                        state <= !hit ? ST_SKIP : (rx_byte[0] ? ST_RDATA : ST_CTRL);
                    end
                    ST_CTRL: begin
                        ack   <= 1'b1;
                        state <= ST_WDATA;
                    end
                    ST_WDATA: ack <= 1'b1;
                    default:  ack <= 1'b0;
                endcase
            end
        end
    end

    srf_addr_match #(.OWN_ADDR(OWN_ADDR), .N_ALIAS(N_ALIAS)) u_match (
        .addr7     (rx_byte[7:1]),
        .alias_en  (alias_en),
        .alias_key (alias_key),
        .bcast_en  (bcast_en),
        .bcast_key (bcast_key),
        .hit       (hit)
    );

    srf_ptr_unit #(
        .LAST(NUM_REGS - 1), .BRT_LO(BRT_LO), .BRT_HI(BRT_HI), .GRP_LO(GRP_LO), .GRP_HI(GRP_HI)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctrl_load),
        .load_val (ctrl_t'(rx_byte)),
        .adv      (wr_en || rd_en),
        .ctrl_q   (ctrl_q)
    );

    srf_reg_bank #(
        .NUM_REGS(NUM_REGS), .CFG_A(CFG_A), .CFG_B(CFG_B),
        .ALIAS_LO(ALIAS_LO), .N_ALIAS(N_ALIAS), .BCAST(BCAST)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (ctrl_q.ptr),
        .wr_data   (rx_byte),
        .rd_en     (rd_en),
        .rd_idx    (ctrl_q.ptr),
        .ai_view   (ctrl_q.ai),
        .rd_data   (rd_data),
        .alias_en  (alias_en),
        .alias_key (alias_key),
        .bcast_en  (bcast_en),
        .bcast_key (bcast_key)
    );

    // R4
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CTRL && rx_valid && quiet) |=> (ctrl_q.ptr == $past(rx_byte[4:0]) && ack));

    // R11
    idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE || state == ST_SKIP) && rx_valid && quiet) |=> (!ack && $stable(ctrl_q)));

    // R8
    read_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

endmodule

// File: tb/serial_regbank_test.sv
module serial_regbank_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0, rd_req = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       ack_valid, ack, rd_valid;
    logic [7:0] rd_data;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    localparam logic [7:0] WA = 8'h2A;   // own address 15h, write
    localparam logic [7:0] RA = 8'h2B;   // own address 15h, read
    localparam logic [1:0] K_ADDR = 2'd0, K_WR = 2'd1, K_RD = 2'd2, K_STOP = 2'd3;

    always #4 clk = ~clk;

    serial_regbank #(.OWN_ADDR(7'h15), .BRT_COUNT(8)) uut (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req),
        .ack_valid(ack_valid), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // {kind, byte, expected}: ADDR/WR expect ack in bit 0, RD expects data.
    localparam logic [17:0] TBL [0:41] = '{
        {K_ADDR, WA, 8'h01}, {K_WR, 8'h00, 8'h01}, {K_STOP, 8'h00, 8'h00},      // R4 ctrl 00
        {K_ADDR, RA, 8'h01}, {K_RD, 8'h00, 8'h11}, {K_RD, 8'h00, 8'h11},        // R1 R5 R8
        {K_STOP, 8'h00, 8'h00},
        {K_ADDR, 8'hE2, 8'h00}, {K_STOP, 8'h00, 8'h00},                         // R3 alias off
        {K_ADDR, 8'hE0, 8'h01}, {K_WR, 8'h90, 8'h01}, {K_WR, 8'hAA, 8'h01},     // R3 broadcast
        {K_WR, 8'hE6, 8'h01}, {K_WR, 8'h55, 8'h01}, {K_STOP, 8'h00, 8'h00},     // R6 11h->00h
        {K_ADDR, WA, 8'h01}, {K_WR, 8'h8E, 8'h01}, {K_STOP, 8'h00, 8'h00},
        {K_ADDR, RA, 8'h01}, {K_RD, 8'h00, 8'hE2}, {K_RD, 8'h00, 8'hE4},
        {K_RD, 8'h00, 8'hAA}, {K_RD, 8'h00, 8'hE6}, {K_RD, 8'h00, 8'h95},       // R10 view 100
        {K_STOP, 8'h00, 8'h00},
        {K_ADDR, 8'hE4, 8'h01}, {K_STOP, 8'h00, 8'h00},                         // R3 alias 2 on
        {K_ADDR, 8'hE0, 8'h00}, {K_STOP, 8'h00, 8'h00},                         // R3 old broadcast
        {K_ADDR, 8'hE6, 8'h01}, {K_STOP, 8'h00, 8'h00},                         // R3 new broadcast
        {K_ADDR, 8'hE2, 8'h00}, {K_STOP, 8'h00, 8'h00},
        {K_ADDR, 8'hAA, 8'h00}, {K_STOP, 8'h00, 8'h00},                         // R3 alias 3 off
        {K_ADDR, 8'h40, 8'h00}, {K_WR, 8'h00, 8'h00}, {K_WR, 8'h77, 8'h00},     // R11 unmatched
        {K_STOP, 8'h00, 8'h00},
        {K_ADDR, RA, 8'h01}, {K_RD, 8'h00, 8'h05}, {K_STOP, 8'h00, 8'h00}       // R2 R11
    };

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
    endtask

    task automatic put(input logic [7:0] b, input bit exp_ack, input string tag);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
        @(negedge clk) rx_valid = 1'b0;
        check(ack_valid && ack == exp_ack, tag, {6'd0, ack_valid, ack}, {7'd1, exp_ack});
    endtask

    task automatic get(input logic [7:0] exp, input string tag);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        check(rd_valid && rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic set_ctrl(input logic [7:0] c);
        pulse_start(); put(WA, 1'b1, "R2 own write"); put(c, 1'b1, "R4 ctrl"); pulse_stop();
    endtask

    task automatic open_read();
        pulse_start(); put(RA, 1'b1, "R2 own read");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!ack_valid && !rd_valid, "R1 reset outputs", {6'd0, ack_valid, rd_valid}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < 42; i++) begin
            logic [1:0] kind;
            logic [7:0] b, e;
            kind = TBL[i][17:16]; b = TBL[i][15:8]; e = TBL[i][7:0];
            case (kind)
                K_ADDR: begin pulse_start(); put(b, e[0], $sformatf("table row %0d address", i)); end
                K_WR:   put(b, e[0], $sformatf("table row %0d write", i));
                K_RD:   get(e, $sformatf("table row %0d read", i));
                default: pulse_stop();
            endcase
        end

        // R7 brightness band 101: ten writes from 02h wrap 09h->02h
        pulse_start(); put(WA, 1'b1, "R7 addr"); put(8'hA2, 1'b1, "R7 ctrl");
        for (int k = 0; k < 10; k++) put(8'h40 + 8'(k), 1'b1, "R7 write");
        pulse_stop();
        set_ctrl(8'h82); open_read();
        for (int k = 0; k < 9; k++) begin
            logic [7:0] e;
            e = (k == 0) ? 8'h48 : (k == 1) ? 8'h49 : (k == 8) ? 8'h00 : 8'h40 + 8'(k);
            get(e, "R7 brightness band");
        end
        pulse_stop();

        // R7 group band 110: 0Bh wraps to 0Ah
        pulse_start(); put(WA, 1'b1, "R7 addr"); put(8'hCA, 1'b1, "R7 ctrl");
        put(8'h60, 1'b1, "R7 write"); put(8'h61, 1'b1, "R7 write"); put(8'h62, 1'b1, "R7 write");
        pulse_stop();
        set_ctrl(8'h8A); open_read();
        get(8'h62, "R7 group wrap"); get(8'h61, "R7 group"); get(8'h00, "R8 next reg");
        pulse_stop();

        // R7 combined band 111: 0Bh wraps to 02h
        pulse_start(); put(WA, 1'b1, "R7 addr"); put(8'hEB, 1'b1, "R7 ctrl");
        put(8'h70, 1'b1, "R7 write"); put(8'h71, 1'b1, "R7 write"); put(8'h72, 1'b1, "R7 write");
        pulse_stop();
        set_ctrl(8'h8B); open_read(); get(8'h70, "R7 combined"); get(8'h00, "R7 combined"); pulse_stop();
        set_ctrl(8'h82); open_read(); get(8'h71, "R7 combined wrap"); get(8'h72, "R7 combined"); pulse_stop();

        // R9 undefined pointer 14h, auto-increment off
        pulse_start(); put(WA, 1'b1, "R9 addr"); put(8'h14, 1'b1, "R9 ctrl");
        put(8'h99, 1'b1, "R9 undefined write acked"); pulse_stop();
        open_read(); get(8'h00, "R9 undefined read"); get(8'h00, "R5 fixed pointer"); pulse_stop();

        // R6 step from 1Fh to 00h, R10 view reflects flags 100
        set_ctrl(8'h9F); open_read(); get(8'h00, "R9 read 1Fh"); get(8'h95, "R6 R10 rollover"); pulse_stop();

        // R11 byte after stop, outside any transaction
        put(8'h00, 1'b0, "R11 byte after stop");
        open_read(); get(8'h05, "R11 control untouched"); pulse_stop();

        // R1 reset in mid-run restores defaults
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        set_ctrl(8'h90); open_read(); get(8'hE8, "R1 alias 3 default"); get(8'hE0, "R1 broadcast default"); pulse_stop();
        set_ctrl(8'h00); open_read(); get(8'h11, "R1 primary default"); pulse_stop();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule